// File: doc/BRIEF.md
# Barrel and Endcap Scintillator Hit Topology Unit

This unit sits between the counter discriminators of a time-of-flight system and the global trigger logic. Every pipeline clock it receives three synchronous hit vectors: the inner and outer layers of a two-layer barrel ring and a single endcap ring. Each barrel position produces a qualified hit only when its inner counter fires together with one of the two outer counters beside it in azimuth. The ring is closed, so the last position neighbours the first. A stray single-layer pulse therefore never becomes a barrel hit.

From the qualified barrel hits the unit forms a saturating hit count and a back-to-back flag. The flag marks two hits roughly half a ring apart, which is the signature of a pair of tracks leaving the interaction point in opposite directions. The endcap hits go straight into a second saturating count. All outputs leave on a fixed four-clock pipeline, and a valid strobe travels with them so that the global trigger can align them with other subsystems.

The unit is pure pipeline logic: one register stage for coincidence forming, two for the adder trees and the opposite-side search, and one for saturation. It runs at the pipeline clock with no stall and accepts a new set of vectors on every cycle.

Top module: `tof_hit_topology`

## Requirements
- R1: Barrel position i is hit when inner bit i is 1 and at least one of outer bits i-1 and i+1 is 1; outer bit i alone never qualifies position i.
- R2: Neighbour indices wrap modulo NB, so position 0 pairs with outer bits NB-1 and 1, and position NB-1 pairs with outer bits NB-2 and 0.
- R3: `barrel_cnt_o` equals the number of hit barrel positions, clamped at 2^CW-1.
- R4: `endcap_cnt_o` equals the number of 1 bits on `endcap_i`, clamped at 2^CW-1.
- R5: `b2b_o` is 1 when some hit position i has a hit at position (i + NB/2 + d) mod NB for some d from -WIN to +WIN, and 0 otherwise.
- R6: Every output reflects the inputs sampled at the rising edge four edges before it appears, and `valid_o` equals `valid_i` delayed by the same four edges, whatever the data.
- R7: While `rst` is high at a rising edge, all outputs go to 0, including `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Input vectors carry a bunch crossing of interest |
| inner_i | input | NB | Inner barrel layer hit bits, bit index = azimuth position |
| outer_i | input | NB | Outer barrel layer hit bits, bit index = azimuth position |
| endcap_i | input | NE | Endcap ring hit bits |
| valid_o | output | 1 | `valid_i` delayed by four clocks |
| barrel_cnt_o | output | CW | Saturated count of qualified barrel hits |
| endcap_cnt_o | output | CW | Saturated count of endcap hits |
| b2b_o | output | 1 | Opposite-side barrel hit pair found |

## Verification
The bench builds the unit with NB=8, NE=10, CW=3, WIN=1 and an adder group of 3. With these values every one of the 65,536 combinations of inner and outer bits can be applied, one per cycle. At the same time the endcap and valid inputs follow their own patterns, so that wrap-around, every opposite-side offset, clamping of both counts at 7 and a tree group that only partly covers the vector are all reached.

// File: rtl/tof_topo_pkg.sv
package tof_topo_pkg;

    // Map any signed index onto a closed ring of n positions.
    function automatic int wrap_idx(input int idx, input int n);
        return ((idx % n) + n) % n;
    endfunction

    // Number of bits needed to hold values 0..v.
    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/tof_bar_coinc.sv
module tof_bar_coinc
    import tof_topo_pkg::*;
#(
    parameter int NB = 88
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] inner_i,
    input  logic [NB-1:0] outer_i,
    output logic [NB-1:0] hits_o
);

    logic [NB-1:0] hits_d;
    logic [NB-1:0] hits_q;

    // R1 / R2: inner counter plus either azimuthal neighbour on the outer layer
    for (genvar i = 0; i < NB; i++) begin : g_pos
        localparam int LEFT  = wrap_idx(i - 1, NB);
        localparam int RIGHT = wrap_idx(i + 1, NB);
        assign hits_d[i] = inner_i[i] & (outer_i[LEFT] | outer_i[RIGHT]);
    end

    always_ff @(posedge clk) begin
        if (rst) hits_q <= '0;
        else     hits_q <= hits_d;
    end

    assign hits_o = hits_q;

    // R1: no more qualified hits than inner counters that fired
    p_hit_has_inner_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(hits_q) <= $countones($past(inner_i)));

endmodule

// File: rtl/tof_pop_tree.sv
module tof_pop_tree
    import tof_topo_pkg::*;
#(
    parameter int N   = 88,
    parameter int GRP = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         bits_i,
    output logic [bits_for(N)-1:0] sum_o
);

    localparam int NG = (N + GRP - 1) / GRP;
    localparam int GW = bits_for(GRP);
    localparam int SW = bits_for(N);

    logic [NG-1:0][GW-1:0] grp_d;
    logic [NG-1:0][GW-1:0] grp_q;
    logic [SW-1:0]         tot_d;
    logic [SW-1:0]         tot_q;

    // First level: one partial count per group of GRP bits
    always_comb begin
        for (int g = 0; g < NG; g++) begin
            grp_d[g] = '0;
            for (int b = 0; b < GRP; b++) begin
                if (g * GRP + b < N) grp_d[g] = grp_d[g] + GW'(bits_i[g * GRP + b]);
            end
        end
    end

    // Second level: sum of the registered partial counts
    always_comb begin
        tot_d = '0;
        for (int g = 0; g < NG; g++) tot_d = tot_d + SW'(grp_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
            tot_q <= '0;
        end else begin
            grp_q <= grp_d;
            tot_q <= tot_d;
        end
    end

    assign sum_o = tot_q;

    // R3 / R4: an empty vector two edges back gives a zero sum
    p_zero_in_zero_sum_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(bits_i, 2) == '0) |-> (tot_q == '0));

endmodule

// File: rtl/tof_b2b_find.sv
module tof_b2b_find
    import tof_topo_pkg::*;
#(
    parameter int NB  = 88,
    parameter int WIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] hits_i,
    output logic          flag_o
);

    localparam int HALF = NB / 2;
    localparam int SPAN = 2 * WIN + 1;

    logic [NB-1:0] pair_d;
    logic [NB-1:0] pair_q;
    logic          flag_q;

    // R5: position i paired with any hit in the window opposite to it
    for (genvar i = 0; i < NB; i++) begin : g_pos
        logic [SPAN-1:0] opp;
        for (genvar d = 0; d < SPAN; d++) begin : g_off
            localparam int FAR = wrap_idx(i + HALF + d - WIN, NB);
            assign opp[d] = hits_i[FAR];
        end
        assign pair_d[i] = hits_i[i] & (|opp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            flag_q <= 1'b0;
        end else begin
            pair_q <= pair_d;
            flag_q <= |pair_q;
        end
    end

    assign flag_o = flag_q;

    // R5: the symmetric window means a pairing is always seen from both ends
    p_pair_symmetric_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(pair_q) != 1);

endmodule

// File: rtl/tof_hit_topology.sv
module tof_hit_topology
    import tof_topo_pkg::*;
#(
    parameter int NB  = 88,
    parameter int NE  = 48,
    parameter int CW  = 4,
    parameter int WIN = 2,
    parameter int GRP = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [NB-1:0] inner_i,
    input  logic [NB-1:0] outer_i,
    input  logic [NE-1:0] endcap_i,
    output logic          valid_o,
    output logic [CW-1:0] barrel_cnt_o,
    output logic [CW-1:0] endcap_cnt_o,
    output logic          b2b_o
);

    localparam int LAT     = 4;
    localparam int CNT_MAX = (1 << CW) - 1;
    localparam int BSW     = bits_for(NB);
    localparam int ESW     = bits_for(NE);

    // Stage 1
    logic [NB-1:0] bar_hits;
    logic [NE-1:0] ec_q;
    // Stages 2..3
    logic [BSW-1:0] bar_sum;
    logic [ESW-1:0] ec_sum;
    logic           b2b_s3;
    // Valid alignment and warm-up tracking
    logic [LAT-1:0] vpipe_q;
    logic [2:0]     warm_q;

    tof_bar_coinc #(.NB(NB)) u_coinc (
        .clk     (clk),
        .rst     (rst),
        .inner_i (inner_i),
        .outer_i (outer_i),
        .hits_o  (bar_hits)
    );

    always_ff @(posedge clk) begin
        if (rst) ec_q <= '0;
        else     ec_q <= endcap_i;
    end

    tof_pop_tree #(.N(NB), .GRP(GRP)) u_bar_sum (
        .clk    (clk),
        .rst    (rst),
        .bits_i (bar_hits),
        .sum_o  (bar_sum)
    );

    tof_pop_tree #(.N(NE), .GRP(GRP)) u_ec_sum (
        .clk    (clk),
        .rst    (rst),
        .bits_i (ec_q),
        .sum_o  (ec_sum)
    );

    tof_b2b_find #(.NB(NB), .WIN(WIN)) u_b2b (
        .clk    (clk),
        .rst    (rst),
        .hits_i (bar_hits),
        .flag_o (b2b_s3)
    );

    // Stage 4: clamp counts and register every output
    always_ff @(posedge clk) begin
        if (rst) begin
            barrel_cnt_o <= '0;
            endcap_cnt_o <= '0;
            b2b_o        <= 1'b0;
        end else begin
            barrel_cnt_o <= (int'(bar_sum) > CNT_MAX) ? CW'(CNT_MAX) : CW'(bar_sum);
            endcap_cnt_o <= (int'(ec_sum)  > CNT_MAX) ? CW'(CNT_MAX) : CW'(ec_sum);
            b2b_o        <= b2b_s3;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe_q <= '0;
            warm_q  <= '0;
        end else begin
            vpipe_q <= {vpipe_q[LAT-2:0], valid_i};
            if (warm_q != 3'(LAT)) warm_q <= warm_q + 3'd1;
        end
    end

    assign valid_o = vpipe_q[LAT-1];

    // R6: strobe follows the input by exactly four edges once the pipe is full
    p_valid_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 3'(LAT)) |-> (valid_o == $past(valid_i, 4)));

    // R5 / R3: an opposite pair implies at least two counted barrel hits
    p_b2b_two_hits_r5: assert property (@(posedge clk) disable iff (rst)
        b2b_o |-> (barrel_cnt_o >= CW'(2)));

    // R7: reset leaves every output low on the following cycle
    p_reset_clears_r7: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && !b2b_o && barrel_cnt_o == '0 && endcap_cnt_o == '0));

endmodule

// File: tb/tof_hit_topology_test.sv
module tof_hit_topology_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB  = 8;
    localparam int NE  = 10;
    localparam int CW  = 3;
    localparam int WIN = 1;
    localparam int GRP = 3;
    localparam int SAT = (1 << CW) - 1;
    localparam int NVEC = 1 << (2 * NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [NB-1:0] inner_i = '0;
    logic [NB-1:0] outer_i = '0;
    logic [NE-1:0] endcap_i = '0;
    logic          valid_o;
    logic [CW-1:0] barrel_cnt_o;
    logic [CW-1:0] endcap_cnt_o;
    logic          b2b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int exp_b [8];
    int exp_e [8];
    int exp_f [8];
    int exp_v [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tof_hit_topology #(.NB(NB), .NE(NE), .CW(CW), .WIN(WIN), .GRP(GRP)) uut (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (valid_i),
        .inner_i      (inner_i),
        .outer_i      (outer_i),
        .endcap_i     (endcap_i),
        .valid_o      (valid_o),
        .barrel_cnt_o (barrel_cnt_o),
        .endcap_cnt_o (endcap_cnt_o),
        .b2b_o        (b2b_o)
    );

    function automatic int ring(input int i);
        return ((i % NB) + NB) % NB;
    endfunction

    function automatic logic [NB-1:0] model_hits(input logic [NB-1:0] inn, input logic [NB-1:0] out);
        logic [NB-1:0] h = '0;
        for (int i = 0; i < NB; i++) h[i] = inn[i] && (out[ring(i - 1)] || out[ring(i + 1)]);
        return h;
    endfunction

    function automatic int sat_ones(input logic [31:0] v);
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(v[i]);
        return (c > SAT) ? SAT : c;
    endfunction

    function automatic int model_b2b(input logic [NB-1:0] h);
        for (int i = 0; i < NB; i++)
            for (int d = -WIN; d <= WIN; d++)
                if (h[i] && h[ring(i + NB / 2 + d)]) return 1;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic directed(input logic [NB-1:0] inn, input logic [NB-1:0] out,
                            input string tag, input int exp_cnt);
        @(negedge clk);
        inner_i = inn;
        outer_i = out;
        endcap_i = '0;
        valid_i = 1'b1;
        repeat (4) @(negedge clk);
        check(tag, int'(barrel_cnt_o), exp_cnt);
    endtask

    initial begin
        // R7: reset holds outputs low even with every input active
        inner_i = '1; outer_i = '1; endcap_i = '1; valid_i = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 valid_o", int'(valid_o), 0);
        check("R7 barrel_cnt_o", int'(barrel_cnt_o), 0);
        check("R7 endcap_cnt_o", int'(endcap_cnt_o), 0);
        check("R7 b2b_o", int'(b2b_o), 0);
        rst = 1'b0;

        // R1: neighbour qualifies, same-index outer does not
        directed(8'b0000_1000, 8'b0001_0000, "R1 right neighbour", 1);
        directed(8'b0000_1000, 8'b0000_0100, "R1 left neighbour", 1);
        directed(8'b0000_1000, 8'b0000_1000, "R1 same index only", 0);
        directed(8'b0000_0000, 8'b1111_1111, "R1 outer alone", 0);
        // R2: wrap at both ends of the ring
        directed(8'b0000_0001, 8'b1000_0000, "R2 pos0 with last", 1);
        directed(8'b1000_0000, 8'b0000_0001, "R2 last with pos0", 1);

        // Exhaustive sweep over inner/outer, one vector per cycle
        for (int k = 0; k < NVEC + 4; k++) begin
            @(negedge clk);
            if (k >= 4) begin
                int s = (k - 4) % 8;
                check("R3 barrel count", int'(barrel_cnt_o), exp_b[s]);
                check("R4 endcap count", int'(endcap_cnt_o), exp_e[s]);
                check("R5 back-to-back", int'(b2b_o), exp_f[s]);
                check("R6 valid delay", int'(valid_o), exp_v[s]);
            end
            if (k < NVEC) begin
                logic [NB-1:0] inn = k[NB-1:0];
                logic [NB-1:0] out = k[2*NB-1:NB];
                logic [NE-1:0] ec  = NE'((k * 37) ^ (k >> 5));
                logic          v   = k[0] ^ k[9] ^ k[13];
                logic [NB-1:0] h   = model_hits(inn, out);
                int s = k % 8;
                inner_i = inn;
                outer_i = out;
                endcap_i = ec;
                valid_i = v;
                exp_b[s] = sat_ones(32'(h));
                exp_e[s] = sat_ones(32'(ec));
                exp_f[s] = model_b2b(h);
                exp_v[s] = int'(v);
            end else begin
                inner_i = '0; outer_i = '0; endcap_i = '0; valid_i = 1'b0;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule